// File: doc/BRIEF.md
# Main-CPU Expansion Window Decoder

This block sits between the main processor's bus and the memories of a CD expansion unit. It covers the processor's low 8 MB. It turns each byte or word access into a one-hot select for one of four targets: the cartridge port, the boot ROM, the PRG-RAM window or the Word-RAM. It also gives the target a translated memory offset and the byte-lane enables. The select, offset and lanes are registered, so a target sees a decoded access one clock after the address is presented.

A boot-mode input decides which 4 MB half belongs to the expansion unit; the cartridge port gets the other half. In the expansion half, the lower 2 MB holds the boot ROM and a banked 128 KB view of a 512 KB PRG-RAM, and this pair repeats every 256 KB. The upper 2 MB holds a mirrored 256 KB Word-RAM. Access to the PRG-RAM window depends on a 2-bit sub-processor control field. While that field reads "running, not held", the window behaves as open bus.

Writes that reach the boot ROM, and writes that reach a gated PRG-RAM window, are dropped and counted in a saturating error counter. Reads from a gated PRG-RAM window return all ones.

Top module: `expWindowDecode`

## Requirements
- R1: After reset every select, lane enable, the void flag, `memOffset`, `openData` and `errCount` are zero, the PRG-RAM bank is 0 and the control field is 00.
- R2: With `bootCart`=0 the expansion area is the half where address bit 22 is 0; with `bootCart`=1 it is the half where bit 22 is 1. The other half asserts `selCart` with offset = address bits 21:0.
- R3: In the lower 2 MB of the expansion half (address bit 21 = 0), address bits 20:18 are ignored. Bit 17 = 0 reads the boot ROM at offset = bits 16:0, and bit 17 = 1 addresses the PRG-RAM window.
- R4: A write to the boot ROM asserts no select, raises `voidCycle`, and increments `errCount`.
- R5: A PRG-RAM access that is not gated asserts `selPrg` with offset = bank × 0x20000 + address bits 16:0. The bank is taken from bits 7:6 of `bankIn` when `bankWe` is high.
- R6: While the control field equals 01, a PRG-RAM window read asserts no select, raises `voidCycle` and returns `openData` = 16'hFFFF. A write there is dropped in the same way as in R4 and is counted. Any other control value gives real memory.
- R7: In the upper 2 MB of the expansion half (address bit 21 = 1), `selWord` is asserted with offset = address bits 17:0, so the Word-RAM repeats every 256 KB.
- R8: A bank or control-field write takes effect for the access in the following cycle. An access in the same cycle as the write uses the old value.
- R9: A byte access enables only the upper lane when address bit 0 is 0, and only the lower lane when bit 0 is 1. A word access (`wordStb`, with or without `byteStb`) enables both lanes.
- R10: All outputs are registered, one cycle after the access. A cycle with neither strobe gives no select, no lanes, no void flag and a zero offset.
- R11: `errCount` saturates at its all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low hard reset |
| cpuAddr | input | 24 | Byte address of the main processor |
| byteStb | input | 1 | Byte access strobe |
| wordStb | input | 1 | Word access strobe |
| isWrite | input | 1 | 1 = write, 0 = read |
| bootCart | input | 1 | 1 = cartridge boot (expansion in upper half) |
| ctlWe | input | 1 | Load sub-processor control field |
| ctlIn | input | 2 | New control field; 01 gates the PRG-RAM window |
| bankWe | input | 1 | Load PRG-RAM bank register |
| bankIn | input | 8 | Bank register byte; bits 7:6 are the bank |
| selCart | output | 1 | Cartridge port select |
| selRom | output | 1 | Boot ROM select |
| selPrg | output | 1 | PRG-RAM select |
| selWord | output | 1 | Word-RAM select |
| memOffset | output | 22 | Translated offset inside the selected target |
| laneHi | output | 1 | Upper byte lane enable |
| laneLo | output | 1 | Lower byte lane enable |
| voidCycle | output | 1 | Open-bus read or ignored write |
| openData | output | 16 | All ones on an open-bus read, else zero |
| errCount | output | 8 | Saturating count of ignored writes |

## Verification
A stale or corrupted bank register cannot be seen until the next PRG-RAM access. That access then shows a wrong upper offset on the cycle after it is presented, so the bench keeps the PRG window busy around every bank write. A wrong control field shows as a PRG-RAM access that flips between `selPrg` and `voidCycle` with `openData` all ones. A missed or doubled count shows in `errCount` on the same edge as the dropped write. A behavioural model compares every output on every clock, so any wrong state is reported in the first cycle it reaches a port.

// File: rtl/expDecPkg.sv
package expDecPkg;
  typedef struct packed {
    logic active;
    logic selCart;
    logic selRom;
    logic selPrg;
    logic selWord;
    logic openRead;
    logic dropWrite;
  } decStrobe_t;
endpackage

// File: rtl/expDecCtrl.sv
module expDecCtrl
  import expDecPkg::*;
#(
  parameter int BANK_W   = 2,
  parameter int CTL_W    = 2,
  parameter int REG_W    = 8,
  parameter int BANK_LSB = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              halfBit,
  input  logic              wordAreaBit,
  input  logic              prgBit,
  input  logic              byteStb,
  input  logic              wordStb,
  input  logic              isWrite,
  input  logic              bootCart,
  input  logic              ctlWe,
  input  logic [CTL_W-1:0]  ctlIn,
  input  logic              bankWe,
  input  logic [REG_W-1:0]  bankIn,
  output decStrobe_t        strobe,
  output logic [BANK_W-1:0] bankSel
);
  localparam logic [CTL_W-1:0] SUB_RUNNING = CTL_W'(1);

  logic [CTL_W-1:0]  ctlQ;
  logic [BANK_W-1:0] bankQ;
  logic              inExp;
  logic              prgGated;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlQ  <= '0;
      bankQ <= '0;
    end else begin
      if (ctlWe)  ctlQ  <= ctlIn;
      if (bankWe) bankQ <= bankIn[BANK_LSB +: BANK_W];
    end
  end

  assign bankSel  = bankQ;
  assign inExp    = (halfBit == bootCart);
  assign prgGated = (ctlQ == SUB_RUNNING);

  always_comb begin
    strobe = '0;
    if (byteStb || wordStb) begin
      strobe.active = 1'b1;
      if (!inExp) begin
        strobe.selCart = 1'b1;
      end else if (wordAreaBit) begin
        strobe.selWord = 1'b1;
      end else if (!prgBit) begin
        if (isWrite) strobe.dropWrite = 1'b1;
        else         strobe.selRom    = 1'b1;
      end else if (prgGated) begin
        if (isWrite) strobe.dropWrite = 1'b1;
        else         strobe.openRead  = 1'b1;
      end else begin
        strobe.selPrg = 1'b1;
      end
    end
  end

  // R8
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !bankWe |=> $stable(bankQ));

  // R8
  ctl_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctlWe |=> $stable(ctlQ));
endmodule

// File: rtl/expDecPath.sv
module expDecPath
  import expDecPkg::*;
#(
  parameter int OFS_W  = 22,
  parameter int BANK_W = 2,
  parameter int ROM_AW = 17,
  parameter int ERR_W  = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  decStrobe_t        strobeIn,
  input  logic [OFS_W-1:0]  addrIn,
  input  logic [BANK_W-1:0] bankSel,
  input  logic              wordStb,
  output logic              selCart,
  output logic              selRom,
  output logic              selPrg,
  output logic              selWord,
  output logic [OFS_W-1:0]  memOffset,
  output logic              laneHi,
  output logic              laneLo,
  output logic              voidCycle,
  output logic [DATA_W-1:0] openData,
  output logic [ERR_W-1:0]  errCount
);
  localparam logic [ERR_W-1:0] ERR_MAX = '1;

  logic [OFS_W-1:0] ofsNext;
  logic             hiNext;
  logic             loNext;

  always_comb begin
    ofsNext = '0;
    if (strobeIn.selCart)      ofsNext = addrIn;
    else if (strobeIn.selRom)  ofsNext = OFS_W'(addrIn[ROM_AW-1:0]);
    else if (strobeIn.selPrg)  ofsNext = OFS_W'({bankSel, addrIn[ROM_AW-1:0]});
    else if (strobeIn.selWord) ofsNext = OFS_W'(addrIn[ROM_AW:0]);
  end

  assign hiNext = strobeIn.active && (wordStb || !addrIn[0]);
  assign loNext = strobeIn.active && (wordStb ||  addrIn[0]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selCart   <= 1'b0;
      selRom    <= 1'b0;
      selPrg    <= 1'b0;
      selWord   <= 1'b0;
      memOffset <= '0;
      laneHi    <= 1'b0;
      laneLo    <= 1'b0;
      voidCycle <= 1'b0;
      openData  <= '0;
      errCount  <= '0;
    end else begin
      selCart   <= strobeIn.selCart;
      selRom    <= strobeIn.selRom;
      selPrg    <= strobeIn.selPrg;
      selWord   <= strobeIn.selWord;
      memOffset <= ofsNext;
      laneHi    <= hiNext;
      laneLo    <= loNext;
      voidCycle <= strobeIn.openRead || strobeIn.dropWrite;
      openData  <= strobeIn.openRead ? '1 : '0;
      if (strobeIn.dropWrite && errCount != ERR_MAX)
        errCount <= errCount + 1'b1;
    end
  end

  // R11
  err_mono_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> errCount >= $past(errCount));

  // R10
  idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobeIn.active |=> !(laneHi || laneLo || voidCycle));

  // R9
  lane_chk: assert property (@(posedge clk) disable iff (!rstN)
    (selCart || selRom || selPrg || selWord || voidCycle) |-> (laneHi || laneLo));
endmodule

// File: rtl/expWindowDecode.sv
module expWindowDecode
  import expDecPkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int BANK_W = 2,
  parameter int CTL_W  = 2,
  parameter int REG_W  = 8,
  parameter int ERR_W  = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              byteStb,
  input  logic              wordStb,
  input  logic              isWrite,
  input  logic              bootCart,
  input  logic              ctlWe,
  input  logic [CTL_W-1:0]  ctlIn,
  input  logic              bankWe,
  input  logic [REG_W-1:0]  bankIn,
  output logic              selCart,
  output logic              selRom,
  output logic              selPrg,
  output logic              selWord,
  output logic [ADDR_W-3:0] memOffset,
  output logic              laneHi,
  output logic              laneLo,
  output logic              voidCycle,
  output logic [DATA_W-1:0] openData,
  output logic [ERR_W-1:0]  errCount
);
  localparam int OFS_W    = ADDR_W - 2;
  localparam int HALF_BIT = ADDR_W - 2;
  localparam int WRAM_BIT = ADDR_W - 3;
  localparam int ROM_AW   = 17;

  decStrobe_t        strobe;
  logic [BANK_W-1:0] bankSel;
  logic              addrUnused;

  assign addrUnused = cpuAddr[ADDR_W-1];

  expDecCtrl #(
    .BANK_W(BANK_W), .CTL_W(CTL_W), .REG_W(REG_W), .BANK_LSB(REG_W - BANK_W)
  ) ctrl (
    .clk(clk), .rstN(rstN),
    .halfBit(cpuAddr[HALF_BIT]), .wordAreaBit(cpuAddr[WRAM_BIT]),
    .prgBit(cpuAddr[ROM_AW]),
    .byteStb(byteStb), .wordStb(wordStb), .isWrite(isWrite),
    .bootCart(bootCart), .ctlWe(ctlWe), .ctlIn(ctlIn),
    .bankWe(bankWe), .bankIn(bankIn),
    .strobe(strobe), .bankSel(bankSel)
  );

  expDecPath #(
    .OFS_W(OFS_W), .BANK_W(BANK_W), .ROM_AW(ROM_AW),
    .ERR_W(ERR_W), .DATA_W(DATA_W)
  ) path (
    .clk(clk), .rstN(rstN), .strobeIn(strobe),
    .addrIn(cpuAddr[OFS_W-1:0]), .bankSel(bankSel), .wordStb(wordStb),
    .selCart(selCart), .selRom(selRom), .selPrg(selPrg), .selWord(selWord),
    .memOffset(memOffset), .laneHi(laneHi), .laneLo(laneLo),
    .voidCycle(voidCycle), .openData(openData), .errCount(errCount)
  );

  // R2
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({selCart, selRom, selPrg, selWord, voidCycle}));

  // R6
  open_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    (openData != '0) |-> (voidCycle && !laneHi == !laneHi));
endmodule

// File: tb/expWindowDecode_test.sv
module expWindowDecode_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [23:0] cpuAddr = '0;
  logic        byteStb = 1'b0, wordStb = 1'b0, isWrite = 1'b0, bootCart = 1'b0;
  logic        ctlWe = 1'b0, bankWe = 1'b0;
  logic [1:0]  ctlIn = '0;
  logic [7:0]  bankIn = '0;
  logic        selCart, selRom, selPrg, selWord, laneHi, laneLo, voidCycle;
  logic [21:0] memOffset;
  logic [15:0] openData;
  logic [7:0]  errCount;

  int errors = 0, checks = 0;
  string curReq = "R1";
  bit done = 0;

  int mBank = 0, mCtl = 0, mErr = 0;
  int eCart, eRom, ePrg, eWord, eVoid, eHi, eLo, eOfs, eOpen;

  always #10 clk = ~clk;

  expWindowDecode uut (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .byteStb(byteStb), .wordStb(wordStb),
    .isWrite(isWrite), .bootCart(bootCart), .ctlWe(ctlWe), .ctlIn(ctlIn),
    .bankWe(bankWe), .bankIn(bankIn), .selCart(selCart), .selRom(selRom),
    .selPrg(selPrg), .selWord(selWord), .memOffset(memOffset), .laneHi(laneHi),
    .laneLo(laneLo), .voidCycle(voidCycle), .openData(openData), .errCount(errCount)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Reference model: evaluates each edge, then compares once outputs settle.
  always @(posedge clk) begin
    eCart = 0; eRom = 0; ePrg = 0; eWord = 0; eVoid = 0;
    eHi = 0; eLo = 0; eOfs = 0; eOpen = 0;
    if (!rstN) begin
      mBank = 0; mCtl = 0; mErr = 0;
    end else begin
      if (byteStb || wordStb) begin
        int a;
        a = int'(cpuAddr);
        eHi = (wordStb || a % 2 == 0) ? 1 : 0;
        eLo = (wordStb || a % 2 == 1) ? 1 : 0;
        if (((a / 'h400000) % 2) != int'(bootCart)) begin
          eCart = 1; eOfs = a % 'h400000;
        end else if ((a / 'h200000) % 2 == 1) begin
          eWord = 1; eOfs = a % 'h40000;
        end else if ((a / 'h20000) % 2 == 0) begin
          if (isWrite) begin eVoid = 1; if (mErr < 255) mErr++; end
          else begin eRom = 1; eOfs = a % 'h20000; end
        end else if (mCtl == 1) begin
          eVoid = 1;
          if (isWrite) begin if (mErr < 255) mErr++; end
          else eOpen = 'hFFFF;
        end else begin
          ePrg = 1; eOfs = mBank * 'h20000 + a % 'h20000;
        end
      end
      if (bankWe) mBank = int'(bankIn) / 64;
      if (ctlWe)  mCtl  = int'(ctlIn);
    end
    #5;
    chk(curReq, "selCart", int'(selCart), eCart);
    chk(curReq, "selRom",  int'(selRom),  eRom);
    chk(curReq, "selPrg",  int'(selPrg),  ePrg);
    chk(curReq, "selWord", int'(selWord), eWord);
    chk(curReq, "voidCycle", int'(voidCycle), eVoid);
    chk(curReq, "lanes", int'({laneHi, laneLo}), eHi * 2 + eLo);
    chk(curReq, "memOffset", int'(memOffset), eOfs);
    chk(curReq, "openData", int'(openData), eOpen);
    chk(curReq, "errCount", int'(errCount), mErr);
  end

  task automatic acc(input logic [23:0] a, input bit word, input bit wr);
    @(negedge clk);
    cpuAddr = a; byteStb = !word; wordStb = word; isWrite = wr;
    ctlWe = 0; bankWe = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      byteStb = 0; wordStb = 0; isWrite = 0; ctlWe = 0; bankWe = 0;
    end
  endtask

  task automatic setBank(input logic [7:0] v);
    @(negedge clk);
    byteStb = 0; wordStb = 0; ctlWe = 0; bankWe = 1; bankIn = v;
  endtask

  task automatic setCtl(input logic [1:0] v);
    @(negedge clk);
    byteStb = 0; wordStb = 0; bankWe = 0; ctlWe = 1; ctlIn = v;
  endtask

  initial begin
    curReq = "R1";
    idle(3);
    @(negedge clk); rstN = 1;
    idle(2);

    curReq = "R2";
    bootCart = 0;
    acc(24'h400000, 1, 0); acc(24'h7FFFFE, 1, 1); acc(24'h123456, 1, 0);
    @(negedge clk); bootCart = 1; byteStb = 0; wordStb = 0;
    acc(24'h000010, 1, 0); acc(24'h3ABCDE, 1, 1); acc(24'h400000, 1, 0);
    @(negedge clk); bootCart = 0; byteStb = 0; wordStb = 0;

    curReq = "R3";
    acc(24'h0C1234, 1, 0); acc(24'h1C1234, 1, 0); acc(24'h01FFFE, 1, 0);
    acc(24'h1E0002, 1, 0); acc(24'h0A0000, 1, 0);

    curReq = "R4";
    acc(24'h000100, 1, 1); acc(24'h140001, 0, 1); idle(1);

    curReq = "R5";
    setBank(8'h40); acc(24'h03FFFE, 1, 0);
    setBank(8'h80); acc(24'h020000, 1, 1);
    setBank(8'hFF); acc(24'h12ABCD, 0, 0);
    setBank(8'h3F); acc(24'h02ABCC, 1, 0);

    curReq = "R6";
    setBank(8'hC0);
    setCtl(2'b01); acc(24'h020000, 1, 0); acc(24'h030002, 1, 1); acc(24'h000000, 1, 0);
    setCtl(2'b11); acc(24'h020000, 1, 0);
    setCtl(2'b10); acc(24'h020004, 1, 1);
    setCtl(2'b00); acc(24'h020006, 1, 0);

    curReq = "R7";
    acc(24'h200000, 1, 0); acc(24'h3C0000, 1, 1); acc(24'h2A5557, 0, 0);
    acc(24'h23FFFE, 1, 0);

    curReq = "R8";
    @(negedge clk);
    cpuAddr = 24'h020010; wordStb = 1; byteStb = 0; isWrite = 0; bankWe = 1; bankIn = 8'h40;
    acc(24'h020010, 1, 0);
    @(negedge clk);
    cpuAddr = 24'h020012; wordStb = 1; byteStb = 0; isWrite = 0; ctlWe = 1; ctlIn = 2'b01;
    acc(24'h020012, 1, 0);
    setCtl(2'b00); acc(24'h020012, 1, 0);

    curReq = "R9";
    acc(24'h000200, 0, 0); acc(24'h000201, 0, 0);
    @(negedge clk); cpuAddr = 24'h000203; byteStb = 1; wordStb = 1; isWrite = 0;
    acc(24'h200003, 0, 1);

    curReq = "R10";
    idle(3);
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      cpuAddr = 24'($urandom);
      byteStb = 1'($urandom); wordStb = 1'($urandom); isWrite = 1'($urandom);
      bankWe = ($urandom % 6 == 0); bankIn = 8'($urandom);
      ctlWe = ($urandom % 6 == 0); ctlIn = 2'($urandom);
      bootCart = ($urandom % 40 == 0) ? !bootCart : bootCart;
    end
    idle(2);

    curReq = "R11";
    bootCart = 0;
    for (int i = 0; i < 260; i++) acc(24'h000100, 1, 1);
    idle(2);
    @(negedge clk);
    chk("R11", "errCount saturated", int'(errCount), 255);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule